// File: doc/BRIEF.md
# Transmit Character-Control Decoder with Word-Sync Sequencer

This block sits in front of an 8b/10b-style encoder in a serial transmit path. Once per character, when the character-rate enable is high, it takes a data byte, a 2-bit control field, a special-select bit and a mode bit. It decides what kind of character the encoder should send: an ordinary data byte, the K28.5 fill character, a special K character named by the byte, or the first character of a word-sync burst. The encoder itself is outside the block.

There are two decode tables. In the select mode, the select bit combines with the control field. In the plain mode, only the control field is used. Both tables share one word-sync sequencer. Each table has its own code for starting the sequencer. Once started, the sequencer emits 16 K characters in a row and cannot be interrupted. During those 16 characters the control inputs are ignored and new start requests are discarded.

Each character passes through two enabled register stages. The inputs are captured on one enabled edge. The decoded result appears on the outputs at the next enabled edge.

Top module: `txchar_ctl`

## Requirements
- R1: While reset is applied and after it ends, and until the second enabled edge, the outputs are `data_out`=0x00, `kflag_out`=0, `ctype_out`=0 and `sync_out`=0. The sequencer is idle with its position counter at zero.
- R2: All inputs (`mode_sel`, `sel_in`, `ctl_in`, `data_in`) are captured together on a rising edge where `chr_en`=1. The decoded character appears on the outputs at the next rising edge where `chr_en`=1. The outputs do not change on edges where `chr_en`=0.
- R3: With `mode_sel`=0 and `ctl_in[0]`=0, the character is data: `ctype_out`=0 (data), `kflag_out`=0 and `data_out`=`data_in`. This holds whatever `sel_in` and `ctl_in[1]` are.
- R4: With `mode_sel`=0, `sel_in`=0 and `ctl_in`=2'b01, the character is fill: `ctype_out`=1, `kflag_out`=1 and `data_out`=0xBC (K28.5).
- R5: With `mode_sel`=0, `sel_in`=0 and `ctl_in`=2'b11, the character is special: `ctype_out`=2, `kflag_out`=1 and `data_out`=`data_in`.
- R6: With `mode_sel`=0, `sel_in`=1 and `ctl_in[0]`=1, a word-sync sequence starts. That character is the sequence's first character.
- R7: With `mode_sel`=1, `sel_in` has no effect. `ctl_in`=2'b00 gives data (as R3), 2'b01 gives fill (as R4) and 2'b10 gives special (as R5).
- R8: With `mode_sel`=1 and `ctl_in`=2'b11, a word-sync sequence starts.
- R9: A word-sync sequence is exactly 16 characters. For each of them `ctype_out`=3, `kflag_out`=1 and `sync_out`=1, and `sync_out` is 0 on every other character. The byte at position i (0..15) is 0xBC for i=0 and for every even i, and 0x3C (K28.1) for every odd i.
- R10: While a sequence runs, the inputs do not affect the outputs and start requests are discarded. A start request on the character right after the 16th begins a new sequence.
- R11: Asserting reset in the middle of a sequence ends the sequence. After reset the next character is decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| chr_en | input | 1 | Character-rate clock enable |
| mode_sel | input | 1 | Decode table select: 0 = select-bit table, 1 = plain table |
| sel_in | input | 1 | Special-select bit, used only when `mode_sel`=0 |
| ctl_in | input | 2 | Per-character control field |
| data_in | input | 8 | Data byte or special-character code |
| data_out | output | 8 | Byte handed to the encoder |
| kflag_out | output | 1 | High when `data_out` is a K character |
| ctype_out | output | 2 | Character type: 0 data, 1 fill, 2 special, 3 sync |
| sync_out | output | 1 | High for each character of a word-sync sequence |

## Verification
Two functions can meet in the same cycle: a start request being decoded, and the sequencer still running. This happens inside a sequence and also on its last character. The bench provokes it in both modes. It issues start codes on several characters inside a running sequence, including the 16th. It then issues another start code on the very next character. Expected results come from a bench-side model of the sequence position. Every mid-sequence request must be discarded and show a table byte. The request on the 17th character must restart at position 0. Enable gaps are placed inside sequences to confirm that the position advances only on enabled characters.

// File: rtl/txc_pkg.sv
package txc_pkg;

  localparam int BYTE_W  = 8;
  localparam int CTL_W   = 2;
  localparam int SEQ_LEN = 16;

  typedef enum logic [1:0] {
    CT_DATA = 2'd0,
    CT_FILL = 2'd1,
    CT_SPEC = 2'd2,
    CT_SYNC = 2'd3
  } ctype_e;

  localparam logic [7:0] K_FILL = 8'hBC;
  localparam logic [7:0] K_ALT  = 8'h3C;

  typedef struct packed {
    logic              mode;
    logic              sel;
    logic [CTL_W-1:0]  ctl;
    logic [BYTE_W-1:0] data;
  } chr_in_t;

  // Position 0 and every even position carry K28.5, odd positions carry K28.1.
  function automatic logic [7:0] sync_entry(int pos);
    return (pos % 2 == 1) ? K_ALT : K_FILL;
  endfunction

endpackage

// File: rtl/txc_rst_sync.sv
module txc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign srst_n = shift_q[STAGES-1];

endmodule

// File: rtl/txc_in_reg.sv
module txc_in_reg
  import txc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  chr_in_t d,
  output chr_in_t q
);

  chr_in_t q_d;

  always_comb begin
    q_d = q;
    if (en) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/txc_decode.sv
module txc_decode
  import txc_pkg::*;
(
  input  chr_in_t c,
  output ctype_e  kind,
  output logic    start
);

  always_comb begin
    kind  = CT_DATA;
    start = 1'b0;
    if (!c.mode) begin
      // select-bit table
      if (!c.ctl[0])    kind = CT_DATA;
      else if (c.sel)   begin kind = CT_SYNC; start = 1'b1; end
      else if (c.ctl[1]) kind = CT_SPEC;
      else              kind = CT_FILL;
    end else begin
      // plain table, select bit unused
      unique case (c.ctl)
        2'b00:   kind = CT_DATA;
        2'b01:   kind = CT_FILL;
        2'b10:   kind = CT_SPEC;
        default: begin kind = CT_SYNC; start = 1'b1; end
      endcase
    end
  end

endmodule

// File: rtl/txc_sync_seq.sv
module txc_sync_seq
  import txc_pkg::*;
#(
  parameter int SEQ_N = 16,
  parameter int BW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  output logic          active,
  output logic [BW-1:0] entry
);

  localparam int IW = $clog2(SEQ_N);
  localparam logic [IW-1:0] LAST = IW'(SEQ_N - 1);

  logic          run_q, run_d;
  logic [IW-1:0] cnt_q, cnt_d, cur_idx;
  logic [BW-1:0] tbl [SEQ_N];

  generate
    for (genvar g = 0; g < SEQ_N; g++) begin : g_tbl
      assign tbl[g] = BW'(sync_entry(g));
    end
  endgenerate

  always_comb begin
    active  = run_q | start;
    cur_idx = run_q ? cnt_q : '0;
    run_d   = run_q;
    cnt_d   = cnt_q;
    if (en && active) begin
      if (cur_idx == LAST) begin
        run_d = 1'b0;
        cnt_d = '0;
      end else begin
        run_d = 1'b1;
        cnt_d = cur_idx + 1'b1;
      end
    end
  end

  assign entry = tbl[cur_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> cnt_q == '0);

  assert_first_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !run_q && start) |=> (run_q && cnt_q == IW'(1)));

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_q && cnt_q != LAST) |=> (run_q && (cnt_q - $past(cnt_q)) == IW'(1)));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_q && cnt_q == LAST) |=> !run_q);

  assert_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q) && $stable(run_q));

endmodule

// File: rtl/txchar_ctl.sv
module txchar_ctl
  import txc_pkg::*;
#(
  parameter int DW        = BYTE_W,
  parameter int SYNC_LEN  = SEQ_LEN,
  parameter int RS_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_en,
  input  logic          mode_sel,
  input  logic          sel_in,
  input  logic [1:0]    ctl_in,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          kflag_out,
  output logic [1:0]    ctype_out,
  output logic          sync_out
);

  logic    srst_n;
  chr_in_t cap_d, cap_q;
  ctype_e  kind;
  logic    start_req;
  logic    seq_act;
  logic [DW-1:0] seq_byte;

  logic [DW-1:0] dout_d;
  logic          k_d, sync_d;
  ctype_e        type_d, type_q;

  txc_rst_sync #(.STAGES(RS_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  always_comb begin
    cap_d.mode = mode_sel;
    cap_d.sel  = sel_in;
    cap_d.ctl  = ctl_in;
    cap_d.data = BYTE_W'(data_in);
  end

  txc_in_reg u_in (
    .clk(clk), .rst_n(srst_n), .en(chr_en), .d(cap_d), .q(cap_q)
  );

  txc_decode u_dec (
    .c(cap_q), .kind(kind), .start(start_req)
  );

  txc_sync_seq #(.SEQ_N(SYNC_LEN), .BW(DW)) u_seq (
    .clk(clk), .rst_n(srst_n), .en(chr_en), .start(start_req),
    .active(seq_act), .entry(seq_byte)
  );

  always_comb begin
    dout_d = data_out;
    k_d    = kflag_out;
    type_d = type_q;
    sync_d = sync_out;
    if (chr_en) begin
      if (seq_act) begin
        dout_d = seq_byte;
        k_d    = 1'b1;
        type_d = CT_SYNC;
        sync_d = 1'b1;
      end else begin
        sync_d = 1'b0;
        type_d = kind;
        unique case (kind)
          CT_FILL: begin dout_d = DW'(K_FILL);     k_d = 1'b1; end
          CT_SPEC: begin dout_d = DW'(cap_q.data); k_d = 1'b1; end
          default: begin dout_d = DW'(cap_q.data); k_d = 1'b0; end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      data_out  <= '0;
      kflag_out <= 1'b0;
      type_q    <= CT_DATA;
      sync_out  <= 1'b0;
    end else begin
      data_out  <= dout_d;
      kflag_out <= k_d;
      type_q    <= type_d;
      sync_out  <= sync_d;
    end
  end

  assign ctype_out = type_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !chr_en |=> $stable({data_out, kflag_out, ctype_out, sync_out}));

  assert_fill_byte_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (ctype_out == 2'd1) |-> (data_out == DW'(K_FILL) && kflag_out));

  assert_sync_kind_R9: assert property (@(posedge clk) disable iff (!srst_n)
    sync_out |-> (kflag_out && ctype_out == 2'd3));

  assert_data_not_k_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (ctype_out == 2'd0) |-> !kflag_out);

endmodule

// File: tb/sim_txchar_ctl.sv
module sim_txchar_ctl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       chr_en;
  logic       mode_sel;
  logic       sel_in;
  logic [1:0] ctl_in;
  logic [7:0] data_in;
  logic [7:0] data_out;
  logic       kflag_out;
  logic [1:0] ctype_out;
  logic       sync_out;

  typedef struct {
    logic [7:0] b;
    logic       k;
    logic [1:0] t;
    logic       s;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   seq_pos = 0;
  logic en_seen = 1'b0;
  logic mon_on  = 1'b0;
  logic done    = 1'b0;
  logic [7:0] last_b;
  logic       last_k, last_s;
  logic [1:0] last_t;

  always #4 clk = ~clk;

  txchar_ctl u0 (
    .clk(clk), .rst_n(rst_n), .chr_en(chr_en), .mode_sel(mode_sel),
    .sel_in(sel_in), .ctl_in(ctl_in), .data_in(data_in),
    .data_out(data_out), .kflag_out(kflag_out), .ctype_out(ctype_out),
    .sync_out(sync_out)
  );

  function automatic logic [7:0] tbl_byte(int p);
    return (p % 2 == 1) ? 8'h3C : 8'hBC;
  endfunction

  task automatic cmp(exp_t e);
    checks++;
    if (data_out !== e.b || kflag_out !== e.k || ctype_out !== e.t || sync_out !== e.s) begin
      fails++;
      $display("FAIL %s: got b=%02h k=%0b t=%0d s=%0b, expected b=%02h k=%0b t=%0d s=%0b",
               e.req, data_out, kflag_out, ctype_out, sync_out, e.b, e.k, e.t, e.s);
    end
  endtask

  // Driver: one enabled character, expected result from the requirement model.
  task automatic send(input logic m, input logic s, input logic [1:0] c,
                      input logic [7:0] d, input string req);
    exp_t e;
    logic start;
    @(negedge clk); #1;
    chr_en = 1'b1; mode_sel = m; sel_in = s; ctl_in = c; data_in = d;
    e.req = req;
    if (seq_pos > 0) begin
      e.b = tbl_byte(seq_pos); e.k = 1'b1; e.t = 2'd3; e.s = 1'b1;
      seq_pos = (seq_pos == 15) ? 0 : seq_pos + 1;
    end else begin
      start = m ? (c == 2'b11) : (s && c[0]);
      e.s = 1'b0;
      if (start) begin
        e.b = tbl_byte(0); e.k = 1'b1; e.t = 2'd3; e.s = 1'b1; seq_pos = 1;
      end else if (!m && !c[0] || m && c == 2'b00) begin
        e.b = d; e.k = 1'b0; e.t = 2'd0;
      end else if (c == 2'b01) begin
        e.b = 8'hBC; e.k = 1'b1; e.t = 2'd1;
      end else begin
        e.b = d; e.k = 1'b1; e.t = 2'd2;
      end
    end
    q.push_back(e);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      chr_en = 1'b0; data_in = 8'hA5; ctl_in = 2'b11; sel_in = 1'b1;
    end
  endtask

  task automatic do_reset();
    exp_t e;
    mon_on = 1'b0;
    @(negedge clk); #1;
    rst_n = 1'b0; chr_en = 1'b0;
    q.delete(); seq_pos = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    e.b = 8'h00; e.k = 1'b0; e.t = 2'd0; e.s = 1'b0; e.req = "R1";
    cmp(e);
    last_b = data_out; last_k = kflag_out; last_t = ctype_out; last_s = sync_out;
    mon_on = 1'b1;
  endtask

  always @(posedge clk) en_seen <= chr_en;

  // Monitor: pops and compares on every enabled edge once the pipeline holds a character.
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (en_seen) begin
        if (q.size() >= 2) cmp(q.pop_front());
      end else begin
        checks++;
        if (data_out !== last_b || kflag_out !== last_k || ctype_out !== last_t || sync_out !== last_s) begin
          fails++;
          $display("FAIL R2: outputs moved without enable, got b=%02h t=%0d, expected b=%02h t=%0d",
                   data_out, ctype_out, last_b, last_t);
        end
      end
      last_b = data_out; last_k = kflag_out; last_t = ctype_out; last_s = sync_out;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; chr_en = 1'b0; mode_sel = 1'b0; sel_in = 1'b0; ctl_in = 2'b00; data_in = 8'h00;
    do_reset();

    // R3: data in select mode, whatever sel and ctl[1]
    send(0, 0, 2'b00, 8'h11, "R3");
    send(0, 1, 2'b00, 8'h22, "R3");
    send(0, 1, 2'b10, 8'h33, "R3");
    gap(2);
    send(0, 0, 2'b10, 8'h44, "R3");
    send(0, 0, 2'b01, 8'h55, "R4");
    send(0, 0, 2'b11, 8'h7C, "R5");
    send(0, 0, 2'b11, 8'hF7, "R5");

    // R6: start in select mode, R9 contents, R10 requests dropped mid-sequence
    send(0, 1, 2'b01, 8'h99, "R6");
    for (int i = 1; i < 16; i++) begin
      if (i == 5) gap(3);
      send(i[0], 1, 2'b11, 8'(i * 7), (i == 15) ? "R10" : "R9");
    end
    // R10: start on the very next character restarts the burst
    send(0, 1, 2'b11, 8'h01, "R10");
    for (int i = 1; i < 16; i++) send(0, 0, 2'b01, 8'h02, "R9");
    send(0, 0, 2'b00, 8'h66, "R9");

    // R7: plain mode, select bit ignored
    send(1, 1, 2'b00, 8'h12, "R7");
    send(1, 0, 2'b00, 8'h34, "R7");
    send(1, 1, 2'b01, 8'h56, "R7");
    send(1, 1, 2'b10, 8'hFB, "R7");
    send(1, 0, 2'b10, 8'hFD, "R7");
    send(1, 1, 2'b11, 8'h00, "R8");
    for (int i = 1; i < 16; i++) begin
      if (i == 9) gap(1);
      send(1, 0, 2'b11, 8'hE0, "R10");
    end
    send(1, 0, 2'b01, 8'h77, "R9");
    send(1, 0, 2'b11, 8'h00, "R8");
    for (int i = 1; i < 16; i++) send(1, 1, 2'b00, 8'h10, "R9");
    send(0, 1, 2'b00, 8'h88, "R3");

    // R11: reset in the middle of a sequence
    send(1, 0, 2'b11, 8'h00, "R8");
    for (int i = 1; i < 6; i++) send(1, 0, 2'b00, 8'h20, "R9");
    do_reset();
    send(1, 0, 2'b00, 8'h5A, "R11");
    send(0, 0, 2'b01, 8'h5B, "R11");
    send(0, 0, 2'b00, 8'h5C, "R11");
    send(0, 0, 2'b00, 8'h5D, "R11");
    gap(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule